// File: doc/BRIEF.md
# Weighted Bit-Flipping Decoder for a Quasi-Cyclic Parity Code

This block corrects a received block of soft samples against a quasi-cyclic low-density parity-check matrix. Each sample arrives as a sign bit, taken as the hard decision, and an unsigned magnitude, taken as its reliability. When a word is loaded, the block records the weakest magnitude seen by every parity check. Those minima do not change while the word is being decoded.

After a start pulse, the block runs one iteration per clock. In each iteration it evaluates every check against the current hard word. It then scores each bit by adding the minimum of every failing check that covers the bit and subtracting the minimum of every satisfied check that covers it. The bit with the highest score is inverted. Decoding ends when every check is satisfied or when the iteration cap is reached. The corrected word, a success flag and the number of bits flipped remain on the outputs until the next load or start.

The matrix is built from L square circulants of size Z placed side by side. Each circulant has W ones per row. The positions of those ones follow from the parameters, so a new code needs no table edits.

Top module: `wbf_decoder`

## Requirements
- R1: After reset, busy_o, done_o and ok_o are 0, iters_o is 0 and word_o is all zeros.
- R2: A load_i pulse that arrives while the block is not busy copies sign_i into word_o (bit i of word_o equals bit i of sign_i). It also clears done_o, ok_o and iters_o. Load takes priority over a start_i in the same cycle.
- R3: At load, each check r stores the smallest 4-bit magnitude among the bits it covers. The magnitude of bit i is taken from mag_i[4i+3:4i].
- R4: The score of bit l is the sum, over the W checks that contain l, of +min when that check's parity is odd and −min when it is even. The score is signed and wide enough that it cannot overflow.
- R5: Each running cycle with a nonzero syndrome inverts exactly one bit, the one with the highest score, and increments iters_o. When scores tie, the lowest bit index wins.
- R6: In the first running cycle that finds every check even, the block enters the done state with ok_o = 1, and iters_o equals the number of flips made. The done state holds word_o and iters_o stable until the next load or start.
- R7: If the syndrome is still nonzero when iters_o equals MAX_ITER, the block finishes with ok_o = 0 and iters_o = MAX_ITER. iters_o never exceeds MAX_ITER.
- R8: While busy_o is 1, load_i and start_i have no effect.
- R9: Row r of H has a 1 in column b·Z+c exactly when (c − r) mod Z equals ((b+1)·k·(k+1)/2) mod Z for some k in 0..W−1.
- R10: A start_i pulse sampled at clock edge t sets busy_o at edge t. If the loaded word already satisfies every check, done_o rises at edge t+1 with ok_o = 1 and iters_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture sign_i and mag_i |
| sign_i | input | L*Z | Hard decisions of the received samples |
| mag_i | input | L*Z*MW | Reliability magnitudes, MW bits per sample |
| start_i | input | 1 | Begin decoding the loaded word |
| busy_o | output | 1 | Decoding in progress |
| done_o | output | 1 | Decoding finished |
| ok_o | output | 1 | All checks satisfied at finish |
| word_o | output | L*Z | Current or corrected hard word |
| iters_o | output | clog2(MAX_ITER+1) | Number of bits flipped |

## Verification
The bench instantiates the block with Z = 15, L = 2, W = 3 and 4-bit magnitudes, which gives a 30-bit word and 15 checks. It lowers the iteration cap to 3 so that a five-error pattern reliably hits the cap and the failure path is exercised. With this small matrix, a two-error pattern can be constructed so that both wrong bits share no check and receive equal scores, which exercises the lowest-index tie rule. Random words are built around the all-zero and all-one codewords (every row has even weight), and errors are placed on low-magnitude samples. Because each run takes only a few cycles, every cycle of each run is compared with the reference.

// File: rtl/wbf_pkg.sv
package wbf_pkg;

  // Offset of the k-th one in the first row of circulant b
  function automatic int hpos(input int b, input int k, input int z);
    return ((b + 1) * k * (k + 1) / 2) % z;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } wbf_state_e;

endpackage

// File: rtl/wbf_check_min.sv
module wbf_check_min
  import wbf_pkg::*;
#(
  parameter int Z  = 15,
  parameter int L  = 2,
  parameter int W  = 3,
  parameter int MW = 4
) (
  input  logic [L*Z*MW-1:0] mag_i,
  output logic [Z*MW-1:0]   cmin_o
);

  for (genvar r = 0; r < Z; r++) begin : g_row
    logic [MW-1:0] low;
    always_comb begin
      low = '1;
      for (int b = 0; b < L; b++) begin
        for (int k = 0; k < W; k++) begin
          if (mag_i[(b*Z + (r + hpos(b, k, Z)) % Z)*MW +: MW] < low)
            low = mag_i[(b*Z + (r + hpos(b, k, Z)) % Z)*MW +: MW];
        end
      end
    end
    assign cmin_o[r*MW +: MW] = low;
  end

endmodule

// File: rtl/wbf_syndrome.sv
module wbf_syndrome
  import wbf_pkg::*;
#(
  parameter int Z = 15,
  parameter int L = 2,
  parameter int W = 3
) (
  input  logic [L*Z-1:0] word_i,
  output logic [Z-1:0]   syn_o
);

  for (genvar r = 0; r < Z; r++) begin : g_row
    logic par;
    always_comb begin
      par = 1'b0;
      for (int b = 0; b < L; b++) begin
        for (int k = 0; k < W; k++) begin
          par = par ^ word_i[b*Z + (r + hpos(b, k, Z)) % Z];
        end
      end
    end
    assign syn_o[r] = par;
  end

endmodule

// File: rtl/wbf_flip_select.sv
module wbf_flip_select
  import wbf_pkg::*;
#(
  parameter int Z  = 15,
  parameter int L  = 2,
  parameter int W  = 3,
  parameter int MW = 4,
  localparam int N  = L * Z,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int EW = $clog2(W * ((1 << MW) - 1) + 1) + 1
) (
  input  logic [Z-1:0]    syn_i,
  input  logic [Z*MW-1:0] cmin_i,
  output logic [IW-1:0]   idx_o
);

  logic signed [EW-1:0] score [N];
  logic signed [EW-1:0] best;

  // Weighted sum over the W checks covering each bit
  always_comb begin
    for (int i = 0; i < N; i++) begin
      score[i] = '0;
      for (int k = 0; k < W; k++) begin
        if (syn_i[((i % Z) - hpos(i / Z, k, Z) + Z) % Z])
          score[i] = score[i] + $signed({{(EW-MW){1'b0}},
                     cmin_i[(((i % Z) - hpos(i / Z, k, Z) + Z) % Z)*MW +: MW]});
        else
          score[i] = score[i] - $signed({{(EW-MW){1'b0}},
                     cmin_i[(((i % Z) - hpos(i / Z, k, Z) + Z) % Z)*MW +: MW]});
      end
    end
  end

  // Strict comparison keeps the lowest index on ties
  always_comb begin
    best  = score[0];
    idx_o = '0;
    for (int i = 1; i < N; i++) begin
      if (score[i] > best) begin
        best  = score[i];
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/wbf_decoder.sv
module wbf_decoder
  import wbf_pkg::*;
#(
  parameter int Z        = 15,
  parameter int L        = 2,
  parameter int W        = 3,
  parameter int MW       = 4,
  parameter int MAX_ITER = 10,
  localparam int N  = L * Z,
  localparam int CW = $clog2(MAX_ITER + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [N-1:0]    sign_i,
  input  logic [N*MW-1:0] mag_i,
  input  logic            start_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            ok_o,
  output logic [N-1:0]    word_o,
  output logic [CW-1:0]   iters_o
);

  wbf_state_e      state_q, state_d;
  logic [N-1:0]    word_q, word_d;
  logic [Z*MW-1:0] cmin_q, cmin_new;
  logic            cmin_en;
  logic [CW-1:0]   iter_q, iter_d;
  logic            ok_q, ok_d;
  logic [Z-1:0]    syn;
  logic [IW-1:0]   flip_idx;

  wbf_check_min #(.Z(Z), .L(L), .W(W), .MW(MW)) u_min (
    .mag_i  (mag_i),
    .cmin_o (cmin_new)
  );

  wbf_syndrome #(.Z(Z), .L(L), .W(W)) u_syn (
    .word_i (word_q),
    .syn_o  (syn)
  );

  wbf_flip_select #(.Z(Z), .L(L), .W(W), .MW(MW)) u_sel (
    .syn_i  (syn),
    .cmin_i (cmin_q),
    .idx_o  (flip_idx)
  );

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    iter_d  = iter_q;
    ok_d    = ok_q;
    cmin_en = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (load_i) begin
          state_d = ST_IDLE;
          word_d  = sign_i;
          cmin_en = 1'b1;
          iter_d  = '0;
          ok_d    = 1'b0;
        end else if (start_i) begin
          state_d = ST_RUN;
          iter_d  = '0;
          ok_d    = 1'b0;
        end
      end
      ST_RUN: begin
        if (syn == '0) begin
          state_d = ST_DONE;
          ok_d    = 1'b1;
        end else if (iter_q == CW'(MAX_ITER)) begin
          state_d = ST_DONE;
          ok_d    = 1'b0;
        end else begin
          word_d = word_q ^ (N'(1) << flip_idx);
          iter_d = iter_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      iter_q  <= '0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      iter_q  <= iter_d;
      ok_q    <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmin_q <= '0;
    else if (cmin_en) cmin_q <= cmin_new;
  end

  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
  assign ok_o    = ok_q;
  assign word_o  = word_q;
  assign iters_o = iter_q;

endmodule

// File: rtl/wbf_decoder_chk.sv
module wbf_decoder_chk #(
  parameter int Z        = 15,
  parameter int L        = 2,
  parameter int W        = 3,
  parameter int MW       = 4,
  parameter int MAX_ITER = 10,
  localparam int N  = L * Z,
  localparam int CW = $clog2(MAX_ITER + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ok_o,
  input logic [N-1:0]  word_o,
  input logic [CW-1:0] iters_o
);

  AST_OK_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> done_o); // R6

  AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    iters_o <= CW'(MAX_ITER)); // R7

  AST_FAIL_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ok_o) |-> (iters_o == CW'(MAX_ITER))); // R7

  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($countones(word_o ^ $past(word_o)) <= 1)); // R5

  AST_FLIP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ((word_o != $past(word_o)) == (iters_o == $past(iters_o) + CW'(1)))); // R5

  AST_BUSY_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && load_i) |=> (busy_o || done_o)); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i && !start_i) |=> (done_o && $stable(word_o) && $stable(iters_o))); // R6

endmodule

bind wbf_decoder wbf_decoder_chk #(
  .Z(Z), .L(L), .W(W), .MW(MW), .MAX_ITER(MAX_ITER)
) u_chk (.*);

// File: tb/tb_wbf_decoder.sv
module tb_wbf_decoder;
  localparam int Z = 15, L = 2, W = 3, MW = 4, MAXIT = 3;
  localparam int N = L * Z;
  localparam int CW = $clog2(MAXIT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, start = 1'b0;
  logic [N-1:0] sign = '0;
  logic [N*MW-1:0] mag = '0;
  logic busy, done, ok;
  logic [N-1:0] word;
  logic [CW-1:0] iters;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wbf_decoder #(.Z(Z), .L(L), .W(W), .MW(MW), .MAX_ITER(MAXIT)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .sign_i(sign), .mag_i(mag),
    .start_i(start), .busy_o(busy), .done_o(done), .ok_o(ok),
    .word_o(word), .iters_o(iters)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Matrix membership from the requirement formula (R9)
  function automatic bit hmem(int r, int col);
    int b = col / Z;
    int c = col % Z;
    for (int k = 0; k < W; k++)
      if ((c - r + Z) % Z == ((b + 1) * k * (k + 1) / 2) % Z) return 1'b1;
    return 1'b0;
  endfunction

  // Reference model state
  int ms = 0, mi = 0;
  bit mok = 1'b0;
  logic [N-1:0] mword = '0;
  int mcmin [Z];

  function automatic bit msyn(int r, logic [N-1:0] w);
    bit s = 1'b0;
    for (int col = 0; col < N; col++) if (hmem(r, col) && w[col]) s = ~s;
    return s;
  endfunction

  function automatic bit mclean(logic [N-1:0] w);
    for (int r = 0; r < Z; r++) if (msyn(r, w)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int mpick(logic [N-1:0] w);
    int best = -100000;
    int bi = 0;
    for (int l = 0; l < N; l++) begin
      int e = 0;
      for (int r = 0; r < Z; r++)
        if (hmem(r, l)) e += msyn(r, w) ? mcmin[r] : -mcmin[r];
      if (e > best) begin best = e; bi = l; end
    end
    return bi;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mi = 0; mok = 1'b0; mword = '0;
    end else if (ms != 1) begin
      if (load) begin
        mword = sign; ms = 0; mi = 0; mok = 1'b0;
        for (int r = 0; r < Z; r++) begin
          mcmin[r] = 15;
          for (int col = 0; col < N; col++)
            if (hmem(r, col) && int'(mag[col*MW +: MW]) < mcmin[r])
              mcmin[r] = int'(mag[col*MW +: MW]);
        end
      end else if (start) begin
        ms = 1; mi = 0; mok = 1'b0;
      end
    end else begin
      if (mclean(mword)) begin ms = 2; mok = 1'b1; end
      else if (mi == MAXIT) begin ms = 2; mok = 1'b0; end
      else begin mword[mpick(mword)] ^= 1'b1; mi++; end
    end
  end

  // Per-cycle comparison with the reference (R4, R5, R6)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 busy", int'(busy), int'(ms == 1));
      chk("R6 done", int'(done), int'(ms == 2));
      chk("R6 ok", int'(ok), int'(mok));
      chk("R6 iters", int'(iters), mi);
      chk("R4/R5 word", int'(word), int'(mword));
    end
  end

  function automatic logic [N*MW-1:0] fill(int v);
    logic [N*MW-1:0] m;
    for (int i = 0; i < N; i++) m[i*MW +: MW] = MW'(v);
    return m;
  endfunction

  task automatic do_load(input logic [N-1:0] s, input logic [N*MW-1:0] m);
    @(negedge clk); load = 1'b1; sign = s; mag = m;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ok", int'(ok), 0);
    chk("R1 iters", int'(iters), 0);
    chk("R1 word", int'(word), 0);

    // Single error
    do_load(N'(1) << 7, fill(8));
    chk("R2 word after load", int'(word), 1 << 7);
    chk("R2 iters after load", int'(iters), 0);
    do_start();
    wait_done();
    chk("R6 single error ok", int'(ok), 1);
    chk("R6 single error iters", int'(iters), 1);
    chk("R6 single error word", int'(word), 0);

    // Clean word
    do_load('0, fill(8));
    do_start();
    chk("R10 busy after start", int'(busy), 1);
    @(negedge clk);
    chk("R10 done one cycle later", int'(done), 1);
    chk("R10 ok", int'(ok), 1);
    chk("R10 iters", int'(iters), 0);

    // Tie between bits 0 and 22
    do_load((N'(1) << 0) | (N'(1) << 22), fill(5));
    do_start();
    chk("R5 before first flip", int'(word), (1 << 0) | (1 << 22));
    @(negedge clk);
    chk("R5 tie low index first", int'(word), 1 << 22);
    wait_done();
    chk("R5 tie iters", int'(iters), 2);
    chk("R5 tie ok", int'(ok), 1);

    // Iteration cap
    do_load(N'(5'b11111), fill(12) & ~fill(15) | (fill(12) & {{(N*MW-5*MW){1'b1}}, {(5*MW){1'b0}}}) | fill(1) & {{(N*MW-5*MW){1'b0}}, {(5*MW){1'b1}}});
    do_start();
    wait_done();
    chk("R7 cap ok", int'(ok), 0);
    chk("R7 cap iters", int'(iters), MAXIT);

    // Load and start ignored while busy
    do_load(N'(1) << 7, fill(8));
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b1; load = 1'b1; sign = '1; mag = fill(0);
    chk("R8 busy while poking", int'(busy), 1);
    @(negedge clk); start = 1'b0; load = 1'b0;
    wait_done();
    chk("R8 word", int'(word), 0);
    chk("R8 ok", int'(ok), 1);
    chk("R8 iters", int'(iters), 1);

    // Random noisy codewords
    for (int t = 0; t < 40; t++) begin
      logic [N-1:0] s;
      logic [N*MW-1:0] m;
      int ne;
      s = ($urandom_range(1, 0) == 1) ? '1 : '0;
      for (int i = 0; i < N; i++) m[i*MW +: MW] = MW'($urandom_range(15, 5));
      ne = $urandom_range(3, 0);
      for (int e = 0; e < ne; e++) begin
        int p = $urandom_range(N - 1, 0);
        s[p] = ~s[p];
        m[p*MW +: MW] = MW'($urandom_range(6, 0));
      end
      do_load(s, m);
      do_start();
      wait_done();
      chk("R3/R9 random final word", int'(word), int'(mword));
      chk("R3/R9 random ok", int'(ok), int'(mok));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule